// File: doc/BRIEF.md
# Sensor SPI Register Access Controller

This block is an SPI master for single-register access on an inertial sensor that talks in 16-bit words. A client presents a read or a write request with an 8-bit register address and, for a write, 16 bits of data. The block drives chip select, serial clock and MOSI, samples MISO, and answers with a one-cycle done pulse that carries the read data. Every frame uses SPI mode 3: the clock idles high, MOSI changes on falling edges, and both sides sample on rising edges.

A read is two chip-select frames. The first carries the address in the upper byte. The second sends zeros and captures the register value. A write is also two frames. Each frame is a byte write with a write flag in bit 15. The low data byte goes to the given address and the high byte goes to the next address. A chip-select setup delay comes before the first clock edge of each frame, and a stall gap separates every pair of frames. Both delays are counted in system clock cycles from a cycles-per-microsecond parameter. The serial clock half period, in system cycles, comes from an input that is latched when a request is accepted. The integrator must keep the resulting SCLK at or below 1 MHz.

The controller is one state machine with these states:
- IDLE: ready is high.
- SETUP: chip select is low and SCLK has not started.
- SHIFT: the 16 bits are clocked.
- GAP: chip select is high and the stall is timed.
- DONE: the response pulse.

The transitions are:
- IDLE→SETUP when a request is accepted.
- SETUP→SHIFT when the setup count expires. The first falling edge is issued at this point.
- SHIFT→GAP after the 32nd half period.
- GAP→SETUP after the stall that follows the first frame.
- GAP→DONE after the stall that follows the second frame.
- DONE→IDLE unconditionally.

Top module: `sensor_reg_spi`

## Requirements
- R1: While reset is held, chip select and SCLK are high, ready is high and the done pulse is low.
- R2: Each frame is 16 bits, MSB first, in SPI mode 3. SCLK is high whenever chip select is high. MOSI changes only on falling SCLK edges. MISO is sampled on rising edges.
- R3: A read sends first {addr[7:0], 8'h00} and then 16'h0000. The read data is the MISO word of the second frame, MSB first.
- R4: A write sends first {1, addr[6:0], wdata[7:0]} and then {1, (addr[6:0]+1) mod 128, wdata[15:8]}.
- R5: Chip select stays high for at least STALL_US×CYC_PER_US system cycles between any two frames, including frames of different requests.
- R6: The first falling SCLK edge of each frame comes exactly SETUP_US×CYC_PER_US cycles after chip select falls.
- R7: Each SCLK half period lasts the divider value latched at acceptance, and a value of 0 acts as 1. The last rising edge is followed by one more half period before chip select rises.
- R8: The divider input has no effect while a request is in progress.
- R9: Ready is low from acceptance until the done pulse. A request offered in that time is not taken and produces no frame.
- R10: Done is exactly one cycle wide, and there is one pulse per request. It appears after the stall that follows the second frame.
- R11: A write leaves the read data output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | SCLK half period in system cycles, latched at acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 16 | Data from the last read |
| spi_csn | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |

## Verification
The hardest conditions to reach from the ports are the mid-transaction ones. One is a change of the divider input after acceptance. The other is a competing request held valid for the whole busy period. Dedicated directed runs produce both. They change the divider right after the accept edge, or keep a different request valid until the done pulse is seen. They then measure every half period and count the frames, so that neither a new rate nor an extra transaction can pass unnoticed. The address-wrap case for writes to address 0x7F is in the vector table. So is a read whose first-frame MISO word differs from the response word, which shows that only the second frame is captured.

// File: rtl/sensor_reg_spi_pkg.sv
package sensor_reg_spi_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_SHIFT,
        S_GAP,
        S_DONE
    } ctl_state_t;

    // Word shifted out in the first frame of a request
    function automatic logic [15:0] first_frame(input logic wr, input logic [7:0] a,
                                                input logic [15:0] d);
        return wr ? {1'b1, a[6:0], d[7:0]} : {a, 8'h00};
    endfunction

    // Word shifted out in the second frame of a request
    function automatic logic [15:0] second_frame(input logic wr, input logic [7:0] a,
                                                 input logic [15:0] d);
        logic [6:0] nxt;
        nxt = a[6:0] + 7'd1;
        return wr ? {1'b1, nxt, d[15:8]} : 16'h0000;
    endfunction

endpackage

// File: rtl/sensor_spi_sclk_gen.sv
module sensor_spi_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == half_div - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

    // R7
    tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q < half_div));
endmodule

// File: rtl/sensor_spi_shifter.sv
module sensor_spi_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              drive,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            mosi    <= 1'b0;
            rx_word <= '0;
        end else begin
            if (load)
                tx_q <= load_word;
            else if (drive) begin
                mosi <= tx_q[WORD_W-1];
                tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            end
            if (sample)
                rx_word <= {rx_word[WORD_W-2:0], miso};
        end
    end

    // R2
    drive_sample_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive && sample));
endmodule

// File: rtl/sensor_reg_spi.sv
module sensor_reg_spi
    import sensor_reg_spi_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int SETUP_US   = 1,
    parameter int STALL_US   = 20,
    parameter int DIV_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [7:0]       req_addr,
    input  logic [15:0]      req_wdata,
    output logic             rsp_valid,
    output logic [15:0]      rsp_rdata,
    output logic             spi_csn,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int SETUP_CYC = CYC_PER_US * SETUP_US;
    localparam int STALL_CYC = CYC_PER_US * STALL_US;
    localparam int DLY_MAX   = (SETUP_CYC > STALL_CYC) ? SETUP_CYC : STALL_CYC;
    localparam int DLY_W     = $clog2(DLY_MAX + 1);
    localparam int HALVES    = 32;

    ctl_state_t       state_q, state_d;
    logic [DLY_W-1:0] dly_q;
    logic [5:0]       edge_q;
    logic             frame_q;
    logic             wr_q;
    logic [7:0]       addr_q;
    logic [15:0]      wdata_q;
    logic [DIV_W-1:0] div_q;
    logic             csn_q, sclk_q;
    logic [15:0]      rdata_q;
    logic [15:0]      rx_word;
    logic             tick, accept, setup_end, gap_end, shift_end;
    logic             sh_load, sh_drive, sh_sample;
    logic [15:0]      sh_word;

    assign accept    = (state_q == S_IDLE) && req_valid;
    assign setup_end = (state_q == S_SETUP) && (dly_q == DLY_W'(SETUP_CYC - 1));
    assign gap_end   = (state_q == S_GAP) && (dly_q == DLY_W'(STALL_CYC - 1));
    assign shift_end = (state_q == S_SHIFT) && tick && (edge_q == 6'(HALVES));

    assign sh_load   = accept || (gap_end && !frame_q);
    assign sh_word   = accept ? first_frame(req_write, req_addr, req_wdata)
                              : second_frame(wr_q, addr_q, wdata_q);
    assign sh_drive  = setup_end ||
                       ((state_q == S_SHIFT) && tick && !edge_q[0] && (edge_q != 6'(HALVES)));
    assign sh_sample = (state_q == S_SHIFT) && tick && edge_q[0];

    sensor_spi_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state_q == S_SHIFT),
        .half_div (div_q),
        .tick     (tick)
    );

    sensor_spi_shifter #(.WORD_W(16)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (sh_word),
        .drive     (sh_drive),
        .sample    (sh_sample),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .rx_word   (rx_word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept)    state_d = S_SETUP;
            S_SETUP: if (setup_end) state_d = S_SHIFT;
            S_SHIFT: if (shift_end) state_d = S_GAP;
            S_GAP:   if (gap_end)   state_d = frame_q ? S_DONE : S_SETUP;
            S_DONE:                 state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and pin registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q   <= '0;
            edge_q  <= '0;
            frame_q <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            div_q   <= DIV_W'(1);
            csn_q   <= 1'b1;
            sclk_q  <= 1'b1;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (accept) begin
                    wr_q    <= req_write;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    div_q   <= (clk_div == '0) ? DIV_W'(1) : clk_div;
                    frame_q <= 1'b0;
                    dly_q   <= '0;
                    csn_q   <= 1'b0;
                end
                S_SETUP: begin
                    dly_q <= dly_q + DLY_W'(1);
                    if (setup_end) begin
                        sclk_q <= 1'b0;
                        edge_q <= 6'd1;
                        dly_q  <= '0;
                    end
                end
                S_SHIFT: if (tick) begin
                    edge_q <= edge_q + 6'd1;
                    if (edge_q[0])
                        sclk_q <= 1'b1;
                    else if (edge_q != 6'(HALVES))
                        sclk_q <= 1'b0;
                    else begin
                        csn_q <= 1'b1;
                        dly_q <= '0;
                    end
                end
                S_GAP: begin
                    dly_q <= dly_q + DLY_W'(1);
                    if (gap_end) begin
                        dly_q <= '0;
                        if (!frame_q) begin
                            frame_q <= 1'b1;
                            csn_q   <= 1'b0;
                        end else if (!wr_q) begin
                            rdata_q <= rx_word;
                        end
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    assign req_ready = (state_q == S_IDLE);
    assign rsp_valid = (state_q == S_DONE);
    assign rsp_rdata = rdata_q;
    assign spi_csn   = csn_q;
    assign spi_sclk  = sclk_q;

    // Cycles chip select has been high, saturating; starts saturated after reset
    localparam int GAP_W = $clog2(STALL_CYC + 1);
    logic [GAP_W-1:0] gap_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          gap_cnt_q <= GAP_W'(STALL_CYC);
        else if (!spi_csn)                   gap_cnt_q <= '0;
        else if (gap_cnt_q < GAP_W'(STALL_CYC)) gap_cnt_q <= gap_cnt_q + GAP_W'(1);
    end

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> spi_sclk);
    // R2
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_mosi) |-> $fell(spi_sclk));
    // R5
    stall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_csn) |-> (gap_cnt_q >= GAP_W'(STALL_CYC)));
    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_csn |-> !req_ready);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> rsp_valid && !wr_q);
endmodule

// File: tb/sensor_reg_spi_tb.sv
`timescale 1ns/1ps
module sensor_reg_spi_tb;
    localparam int CPU   = 4;
    localparam int SETUP = CPU * 1;
    localparam int STALL = CPU * 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = 8'd1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid, spi_csn, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [15:0] rsp_rdata;

    always #2.5 clk = ~clk;

    sensor_reg_spi #(.CYC_PER_US(CPU), .SETUP_US(1), .STALL_US(20), .DIV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // {write, addr, wdata, miso response, divider}
    localparam logic [48:0] VEC [7] = '{
        {1'b0, 8'h72, 16'h0000, 16'h4079, 8'd2},
        {1'b0, 8'h02, 16'h0000, 16'h8001, 8'd1},
        {1'b1, 8'h5C, 16'h0000, 16'h0000, 8'd3},
        {1'b1, 8'h60, 16'h02C1, 16'h0000, 8'd2},
        {1'b1, 8'h7F, 16'hBEEF, 16'h0000, 8'd1},
        {1'b0, 8'hFF, 16'h0000, 16'hFFFF, 8'd4},
        {1'b0, 8'h00, 16'h0000, 16'h0000, 8'd0}
    };

    // Slave model and timing monitor, sampled on the falling system clock edge
    int          cyc = 0, t_fall = 0, t_rise = 0, last_edge = 0, bit_i = 0, fidx = 0;
    int          bad_setup = 0, bad_half = 0, idle_bad = 0, min_gap = 1 << 30, exp_div = 1;
    bit          first_fall = 0, have_rise = 0, prev_csn = 1, prev_sclk = 1;
    logic [15:0] cap = '0, cur_resp = '0;
    logic [15:0] frames [4];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_csn && !spi_csn) begin
                t_fall = cyc; first_fall = 1; bit_i = 0;
                if (have_rise && (cyc - t_rise) < min_gap) min_gap = cyc - t_rise;
            end
            if (prev_sclk && !spi_sclk) begin
                if (first_fall) begin
                    if (cyc - t_fall != SETUP) bad_setup++;
                    first_fall = 0;
                end else if (cyc - last_edge != exp_div) bad_half++;
                last_edge = cyc;
                if (bit_i < 16) spi_miso = (fidx == 1) ? cur_resp[15 - bit_i] : 16'hA5A5 >> (15 - bit_i);
                bit_i++;
            end
            if (!prev_sclk && spi_sclk && !spi_csn) begin
                if (cyc - last_edge != exp_div) bad_half++;
                last_edge = cyc;
                cap = {cap[14:0], spi_mosi};
            end
            if (!prev_csn && spi_csn) begin
                if (cyc - last_edge != exp_div) bad_half++;
                if (fidx < 4) frames[fidx] = cap;
                fidx++;
                t_rise = cyc; have_rise = 1;
            end
            if (spi_csn && !spi_sclk) idle_bad++;
        end
        prev_csn = spi_csn;
        prev_sclk = spi_sclk;
    end

    function automatic logic [15:0] exp_first(input bit w, input logic [7:0] a, input logic [15:0] d);
        return w ? {1'b1, a[6:0], d[7:0]} : {a, 8'h00};
    endfunction
    function automatic logic [15:0] exp_second(input bit w, input logic [7:0] a, input logic [15:0] d);
        logic [6:0] n;
        n = a[6:0] + 7'd1;
        return w ? {1'b1, n, d[15:8]} : 16'h0000;
    endfunction

    logic [15:0] last_read = '0;

    task automatic run_txn(input bit w, input logic [7:0] a, input logic [15:0] d,
                           input logic [15:0] resp, input logic [7:0] div,
                           input bit poke_busy, input bit change_div);
        int n;
        int busy_bad;
        logic [15:0] got;
        busy_bad = 0;
        @(posedge clk); #1;
        clk_div = div; req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
        fidx = 0; bad_setup = 0; bad_half = 0; idle_bad = 0; min_gap = 1 << 30;
        exp_div = (div == 0) ? 1 : int'(div); cur_resp = resp;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (change_div) clk_div = div + 8'd3;
        if (poke_busy) begin
            req_valid = 1'b1; req_addr = ~a; req_write = ~w; req_wdata = ~d;
        end
        n = 0;
        forever begin
            @(negedge clk);
            if (rsp_valid) break;
            if (req_ready) busy_bad++;
            n++;
            if (n > 20000) break;
        end
        got = rsp_rdata;
        chk(n <= 20000, "R10 done pulse arrives", n, 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_valid, "R10 done one cycle wide", rsp_valid, 0);
        repeat (6) @(negedge clk);
        chk(busy_bad == 0, "R9 ready low while busy", busy_bad, 0);
        chk(fidx == 2, "R9/R10 two frames per request", fidx, 2);
        chk(frames[0] == exp_first(w, a, d), w ? "R4 write first frame" : "R3 read first frame",
            frames[0], exp_first(w, a, d));
        chk(frames[1] == exp_second(w, a, d), w ? "R4 write second frame" : "R3 read second frame",
            frames[1], exp_second(w, a, d));
        if (w) chk(got == last_read, "R11 write keeps read data", got, last_read);
        else begin
            chk(got == resp, "R3 read data", got, resp);
            last_read = resp;
        end
        chk(bad_setup == 0, "R6 setup delay", bad_setup, 0);
        chk(bad_half == 0, change_div ? "R8 divider ignored while busy" : "R7 half period",
            bad_half, 0);
        chk(min_gap >= STALL, "R5 stall gap", min_gap, STALL);
        chk(idle_bad == 0, "R2 sclk idles high", idle_bad, 0);
        chk(req_ready && spi_csn, "R9 idle after done", req_ready, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(spi_csn == 1'b1, "R1 reset csn", spi_csn, 1);
        chk(spi_sclk == 1'b1, "R1 reset sclk", spi_sclk, 1);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 reset done", rsp_valid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        for (int i = 0; i < 7; i++) begin
            run_txn(VEC[i][48], VEC[i][47:40], VEC[i][39:24], VEC[i][23:8], VEC[i][7:0], 1'b0, 1'b0);
        end

        // R8: divider input changed right after acceptance
        run_txn(1'b0, 8'h6C, 16'h0000, 16'h1234, 8'd2, 1'b0, 1'b1);
        // R9: competing request held during the whole transaction
        run_txn(1'b1, 8'h64, 16'h5AC3, 16'h0000, 8'd1, 1'b1, 1'b0);
        // back-to-back read after the held request, stall measured across requests (R5)
        run_txn(1'b0, 8'h0E, 16'h0000, 16'hC35A, 8'd1, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule